// File: doc/BRIEF.md
# UART Low-Power Sequencer and Interrupt Combiner

This block is the control side of a UART on a microcontroller bus. It decides whether the serial engine's clock runs, based on the CPU's wait and stop indications and a programmable freeze-in-wait bit. When the engine is frozen, a transfer in progress keeps its bit position. An interrupt wake lets the transfer go on from that point. A reset wake aborts the transfer and returns all UART control state to reset.

The block runs on an always-on low-power clock. Its receive-line edge detector therefore keeps working while the bus clock is gated, and a detected edge can request a CPU wake. Eight status flags are captured from raw event pulses, from the edge detector and from a single-wire bit comparison. Each flag is cleared by writing a one to its bit. The flags are combined with their local enables into one level-sensitive interrupt request. The baud generator and the shift registers sit outside the block and follow `clk_en`, `freeze` and `abort`.

Top module: `uart_pm_ctrl`

## Requirements
- R1: After reset, `clk_en`=1, `freeze`=0, `abort`=0, `flags`=0, `irq`=0, `wake_req`=0, `tx_en`=0 and `rx_en`=0.
- R2: With the freeze-in-wait bit (cfg bit 0) clear, asserting `cpu_wait` leaves `clk_en`=1 and `freeze`=0.
- R3: With cfg bit 0 set, `cpu_wait` gives `freeze`=1 and `clk_en`=0 one cycle later. `tx_en` (cfg bit 2) and `rx_en` (cfg bit 3) keep their values.
- R4: `cpu_stop` gives `freeze`=1 and `clk_en`=0 one cycle later, whatever cfg bit 0 holds. The configuration and the flags are kept.
- R5: `wake_irq` while frozen gives `freeze`=0 and `clk_en`=1 one cycle later. It causes no `abort`, and the configuration and the flags are kept, so the transfer resumes.
- R6: `wake_rst` gives a one-cycle `abort` pulse in the next cycle. At that edge it clears the flags and the configuration and returns to the running state.
- R7: The RX pin passes through a two-stage synchronizer. A falling edge (cfg bit 1 = 0) or a rising edge (cfg bit 1 = 1) sets flag bit 5 on the third clock edge after the pin changes. An edge of the other direction does not set it.
- R8: The edge detector keeps working in stop mode. If the edge enable (cfg bit 8) is set while stopped, a detected edge also gives a one-cycle `wake_req` pulse in the same cycle as the flag.
- R9: When `sw_chk` is high and `sw_tx_bit` differs from `sw_rx_bit`, flag bit 6 is set one cycle later. When the two bits match, it is not set.
- R10: The raw pulses `ev_raw[4:0]` (transmit empty, transmit complete, receive full, idle, overrun) set flag bits 4:0. `ev_raw[5]` (break) sets flag bit 7. Each flag is set one cycle after its pulse.
- R11: A one on `flag_clr[i]` clears flag i one cycle later and leaves the other flags alone. A set event in the same cycle wins over the clear.
- R12: `irq` is the OR of each flag ANDed with its enable. The enables are cfg bits 10:4, for flags 0,1,2,3,5,6,7 in that order. The overrun flag (bit 4) uses the receive-full enable (cfg bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-power clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wait | input | 1 | CPU is in wait mode |
| cpu_stop | input | 1 | CPU is in stop mode |
| wake_irq | input | 1 | CPU woken by an interrupt |
| wake_rst | input | 1 | CPU woken by a reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 11 | Configuration word (freeze, polarity, tx/rx enable, interrupt enables) |
| ev_raw | input | 6 | Raw status pulses from the serial engine |
| sw_chk | input | 1 | Single-wire readback compare strobe |
| sw_tx_bit | input | 1 | Bit that was transmitted |
| sw_rx_bit | input | 1 | Bit that was read back from the line |
| rx_pin | input | 1 | Asynchronous receive line |
| flag_clr | input | 8 | Write-one-to-clear strobes, one per flag |
| clk_en | output | 1 | Serial clock enable |
| freeze | output | 1 | Engine holds its position |
| abort | output | 1 | One-cycle pulse that drops the transfer in progress |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| wake_req | output | 1 | Edge wake request while stopped |
| flags | output | 8 | Status flags |
| irq | output | 1 | Combined level interrupt request |

## Verification
Power-state changes, `abort`, flag sets and flag clears all show up one clock edge after the inputs are sampled. `irq` follows the flags and enables in the same cycle. An RX edge reaches the edge flag and `wake_req` on the third edge after the pin changes. The bench drives every input on a falling clock edge and reads the outputs on a later falling edge, counted exactly: one tick for registered results and three for the edge path. It also checks the edge flag one tick early to confirm that it has not yet risen.

// File: rtl/uart_pm_pkg.sv
package uart_pm_pkg;

    localparam int NFLAG  = 8;
    localparam int NRAW   = 6;
    localparam int NIE    = 7;
    localparam int CFG_W  = 4 + NIE;

    localparam int F_TXE  = 0;
    localparam int F_TXC  = 1;
    localparam int F_RXF  = 2;
    localparam int F_IDLE = 3;
    localparam int F_OVR  = 4;
    localparam int F_EDGE = 5;
    localparam int F_BERR = 6;
    localparam int F_BRK  = 7;

    localparam int IE_RXF  = 2;
    localparam int IE_EDGE = 4;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2
    } pm_state_t;

    typedef struct packed {
        logic [NIE-1:0] ie;
        logic           re;
        logic           te;
        logic           rx_pol;
        logic           wait_frz;
    } cfg_t;

    function automatic logic [NFLAG-1:0] enable_vec(input logic [NIE-1:0] ie);
        logic [NFLAG-1:0] v;
        v[F_TXE]  = ie[0];
        v[F_TXC]  = ie[1];
        v[F_RXF]  = ie[2];
        v[F_IDLE] = ie[3];
        v[F_OVR]  = ie[IE_RXF];
        v[F_EDGE] = ie[4];
        v[F_BERR] = ie[5];
        v[F_BRK]  = ie[6];
        return v;
    endfunction

    function automatic logic [NFLAG-1:0] raw_to_set(input logic [NRAW-1:0] raw,
                                                   input logic edge_hit,
                                                   input logic bit_err);
        logic [NFLAG-1:0] s;
        s[F_OVR:F_TXE] = raw[4:0];
        s[F_EDGE]      = edge_hit;
        s[F_BERR]      = bit_err;
        s[F_BRK]       = raw[5];
        return s;
    endfunction

endpackage

// File: rtl/uart_pm_fsm.sv
module uart_pm_fsm
    import uart_pm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_wait,
    input  logic cpu_stop,
    input  logic wake_irq,
    input  logic wake_rst,
    input  logic wait_frz,
    output logic running,
    output logic in_stop,
    output logic abort
);
    pm_state_t state_q, state_d;
    logic      abort_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN: begin
                if (cpu_stop)                  state_d = PM_STOP;
                else if (cpu_wait && wait_frz) state_d = PM_WAIT;
            end
            PM_WAIT: begin
                if (wake_irq)      state_d = PM_RUN;
                else if (cpu_stop) state_d = PM_STOP;
            end
            PM_STOP: begin
                if (wake_irq) state_d = PM_RUN;
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || wake_rst) state_q <= PM_RUN;
        else                 state_q <= state_d;
        abort_q <= rst ? 1'b0 : wake_rst;
    end

    assign running = (state_q == PM_RUN);
    assign in_stop = (state_q == PM_STOP);
    assign abort   = abort_q;
endmodule

// File: rtl/uart_pm_edge.sv
module uart_pm_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_pin,
    input  logic rx_pol,
    output logic edge_hit
);
    logic [SYNC:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q[0] <= 1'b1;
        else     sh_q[0] <= rx_pin;
    end

    for (genvar i = 1; i <= SYNC; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sh_q[i] <= 1'b1;
            else     sh_q[i] <= sh_q[i-1];
        end
    end

    logic cur, prev;
    assign cur  = sh_q[SYNC-1];
    assign prev = sh_q[SYNC];
    assign edge_hit = rx_pol ? (cur & ~prev) : (~cur & prev);
endmodule

// File: rtl/uart_pm_flags.sv
module uart_pm_flags
    import uart_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set_vec,
    input  logic [NFLAG-1:0] clr_vec,
    input  logic [NIE-1:0]   ie,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    logic [NFLAG-1:0] flags_q;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags_q[i] <= 1'b0;
            else if (set_vec[i]) flags_q[i] <= 1'b1;
            else if (clr_vec[i]) flags_q[i] <= 1'b0;
        end
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & enable_vec(ie));
endmodule

// File: rtl/uart_pm_ctrl.sv
module uart_pm_ctrl
    import uart_pm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wait,
    input  logic             cpu_stop,
    input  logic             wake_irq,
    input  logic             wake_rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [NRAW-1:0]  ev_raw,
    input  logic             sw_chk,
    input  logic             sw_tx_bit,
    input  logic             sw_rx_bit,
    input  logic             rx_pin,
    input  logic [NFLAG-1:0] flag_clr,
    output logic             clk_en,
    output logic             freeze,
    output logic             abort,
    output logic             tx_en,
    output logic             rx_en,
    output logic             wake_req,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    logic rst_int;
    assign rst_int = rst | wake_rst;

    cfg_t cfg_q;
    always_ff @(posedge clk) begin
        if (rst_int)     cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
    end

    logic running, in_stop;
    uart_pm_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cpu_wait (cpu_wait),
        .cpu_stop (cpu_stop),
        .wake_irq (wake_irq),
        .wake_rst (wake_rst),
        .wait_frz (cfg_q.wait_frz),
        .running  (running),
        .in_stop  (in_stop),
        .abort    (abort)
    );

    logic edge_hit;
    uart_pm_edge #(.SYNC(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst_int),
        .rx_pin   (rx_pin),
        .rx_pol   (cfg_q.rx_pol),
        .edge_hit (edge_hit)
    );

    logic bit_err;
    assign bit_err = sw_chk & (sw_tx_bit ^ sw_rx_bit);

    uart_pm_flags u_flags (
        .clk     (clk),
        .rst     (rst_int),
        .set_vec (raw_to_set(ev_raw, edge_hit, bit_err)),
        .clr_vec (flag_clr),
        .ie      (cfg_q.ie),
        .flags   (flags),
        .irq     (irq)
    );

    logic wake_q;
    always_ff @(posedge clk) begin
        if (rst_int) wake_q <= 1'b0;
        else         wake_q <= edge_hit & in_stop & cfg_q.ie[IE_EDGE];
    end

    assign clk_en   = running;
    assign freeze   = ~running;
    assign tx_en    = cfg_q.te;
    assign rx_en    = cfg_q.re;
    assign wake_req = wake_q;
endmodule

// File: rtl/uart_pm_chk.sv
module uart_pm_chk (
    input logic       clk,
    input logic       rst,
    input logic       cpu_wait,
    input logic       cpu_stop,
    input logic       wake_irq,
    input logic       wake_rst,
    input logic       wait_frz,
    input logic       freeze,
    input logic       abort,
    input logic       wake_req,
    input logic [7:0] flags,
    input logic       irq
);
    AST_NO_WAIT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!freeze && !cpu_stop && !wake_rst && !wait_frz) |=> !freeze); // R2
    AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!freeze && !cpu_stop && !wake_rst && cpu_wait && wait_frz) |=> freeze); // R3
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!freeze && cpu_stop && !wake_rst) |=> freeze); // R4
    AST_IRQ_RESUME: assert property (@(posedge clk) disable iff (rst)
        (freeze && wake_irq && !wake_rst) |=> (!freeze && !abort)); // R5
    AST_RST_ABORT: assert property (@(posedge clk) disable iff (rst)
        wake_rst |=> (abort && !freeze && flags == 8'h00)); // R6
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (abort && !wake_rst) |=> !abort); // R6
    AST_WAKE_FLAG: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> flags[5]); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (flags == 8'h00) |-> !irq); // R12
endmodule

bind uart_pm_ctrl uart_pm_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_wait (cpu_wait),
    .cpu_stop (cpu_stop),
    .wake_irq (wake_irq),
    .wake_rst (wake_rst),
    .wait_frz (cfg_q.wait_frz),
    .freeze   (freeze),
    .abort    (abort),
    .wake_req (wake_req),
    .flags    (flags),
    .irq      (irq)
);

// File: tb/uart_pm_ctrl_tb.sv
module uart_pm_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_wait, cpu_stop, wake_irq, wake_rst, cfg_we;
    logic [10:0] cfg_wdata;
    logic [5:0]  ev_raw;
    logic        sw_chk, sw_tx_bit, sw_rx_bit, rx_pin;
    logic [7:0]  flag_clr;
    logic        clk_en, freeze, abort, tx_en, rx_en, wake_req, irq;
    logic [7:0]  flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_pm_ctrl u_dut (
        .clk(clk), .rst(rst), .cpu_wait(cpu_wait), .cpu_stop(cpu_stop),
        .wake_irq(wake_irq), .wake_rst(wake_rst), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .ev_raw(ev_raw), .sw_chk(sw_chk),
        .sw_tx_bit(sw_tx_bit), .sw_rx_bit(sw_rx_bit), .rx_pin(rx_pin),
        .flag_clr(flag_clr), .clk_en(clk_en), .freeze(freeze), .abort(abort),
        .tx_en(tx_en), .rx_en(rx_en), .wake_req(wake_req), .flags(flags), .irq(irq)
    );

    // vector: ev_raw[5:0], ie[6:0], expected irq
    localparam int NV = 7;
    localparam logic [13:0] VEC [NV] = '{
        {6'b000001, 7'b0000000, 1'b0},
        {6'b000001, 7'b0000001, 1'b1},
        {6'b010000, 7'b0000100, 1'b1},
        {6'b010000, 7'b1111011, 1'b0},
        {6'b100000, 7'b1000000, 1'b1},
        {6'b001000, 7'b0000010, 1'b0},
        {6'b000010, 7'b0000010, 1'b1}
    };

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [10:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        flag_clr = 8'hFF;
        tick();
        flag_clr = 8'h00;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cpu_wait = 0; cpu_stop = 0; wake_irq = 0; wake_rst = 0;
        cfg_we = 0; cfg_wdata = '0; ev_raw = '0; sw_chk = 0; sw_tx_bit = 0;
        sw_rx_bit = 0; rx_pin = 1'b1; flag_clr = '0;
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 clk_en", clk_en, 1);
        check("R1 freeze", freeze, 0);
        check("R1 abort", abort, 0);
        check("R1 flags", flags, 0);
        check("R1 irq", irq, 0);
        check("R1 te/re", {tx_en, rx_en}, 0);

        // R10 R12 vector walk
        for (int v = 0; v < NV; v++) begin
            logic [5:0] ev;
            logic [7:0] expf;
            ev = VEC[v][13:8];
            expf = {ev[5], 2'b00, ev[4:0]};
            write_cfg({VEC[v][7:1], 4'b0000});
            clear_all();
            ev_raw = ev;
            tick();
            ev_raw = '0;
            check("R10 flags", flags, expf);
            check("R12 irq", irq, VEC[v][0]);
        end

        // R11 set wins over clear, clear is per bit
        write_cfg('0);
        clear_all();
        ev_raw = 6'b000011;
        tick();
        ev_raw = 6'b000001; flag_clr = 8'h01;
        tick();
        ev_raw = '0; flag_clr = 8'h00;
        check("R11 set wins", flags, 8'h03);
        flag_clr = 8'h01;
        tick();
        flag_clr = 8'h00;
        check("R11 clear one bit", flags, 8'h02);
        clear_all();

        // R9 single-wire bit error
        sw_chk = 1; sw_tx_bit = 1; sw_rx_bit = 1;
        tick();
        check("R9 match no error", flags[6], 0);
        sw_rx_bit = 0;
        tick();
        sw_chk = 0;
        check("R9 mismatch error", flags[6], 1);
        clear_all();

        // R7 falling edge, polarity 0
        rx_pin = 1'b0;
        tick(2);
        check("R7 not yet", flags[5], 0);
        tick();
        check("R7 falling sets", flags[5], 1);
        clear_all();
        rx_pin = 1'b1;
        tick(4);
        check("R7 rising ignored pol0", flags[5], 0);
        // polarity 1: rising edge
        write_cfg(11'b000_0000_0010);
        rx_pin = 1'b0;
        tick(4);
        check("R7 falling ignored pol1", flags[5], 0);
        rx_pin = 1'b1;
        tick(3);
        check("R7 rising sets pol1", flags[5], 1);
        clear_all();

        // R2 wait without freeze
        write_cfg(11'b000_0000_1100);
        cpu_wait = 1;
        tick(3);
        check("R2 clk_en in wait", clk_en, 1);
        check("R2 no freeze", freeze, 0);
        cpu_wait = 0;

        // R3 wait with freeze; te/re kept
        write_cfg(11'b000_0000_1101);
        ev_raw = 6'b000100;
        tick();
        ev_raw = '0;
        cpu_wait = 1;
        tick();
        check("R3 freeze", freeze, 1);
        check("R3 clk_en off", clk_en, 0);
        check("R3 te/re kept", {tx_en, rx_en}, 2'b11);

        // R5 interrupt wake resumes
        cpu_wait = 0; wake_irq = 1;
        tick();
        wake_irq = 0;
        check("R5 resume", {clk_en, freeze, abort}, 3'b100);
        check("R5 flags kept", flags, 8'h04);
        check("R5 cfg kept", {tx_en, rx_en}, 2'b11);

        // R4 stop with freeze bit clear
        write_cfg(11'b001_0000_1100);
        cpu_stop = 1;
        tick();
        check("R4 stop freeze", {clk_en, freeze}, 2'b01);
        check("R4 flags kept", flags, 8'h04);

        // R8 edge detection and wake while stopped
        rx_pin = 1'b0;
        tick(3);
        check("R8 wake_req", wake_req, 1);
        check("R8 edge flag", flags[5], 1);
        tick();
        check("R8 wake pulse ends", wake_req, 0);
        check("R4 still frozen", freeze, 1);
        rx_pin = 1'b1;
        cpu_stop = 0; wake_irq = 1;
        tick();
        wake_irq = 0;
        check("R5 stop resume", {clk_en, abort}, 2'b10);
        check("R5 stop flags kept", flags, 8'h24);

        // R6 reset wake aborts
        write_cfg(11'b000_0000_1101);
        cpu_wait = 1;
        tick();
        check("R3 frozen again", freeze, 1);
        cpu_wait = 0; wake_rst = 1;
        tick();
        wake_rst = 0;
        check("R6 abort pulse", abort, 1);
        check("R6 running", clk_en, 1);
        check("R6 flags cleared", flags, 0);
        check("R6 cfg cleared", {tx_en, rx_en}, 0);
        tick();
        check("R6 abort one cycle", abort, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule